// File: doc/BRIEF.md
# Prescaled-clock SPI master

This block is a single-byte SPI master that sits behind a 32-bit register interface. Software sets the clock divider, the clock polarity and phase, and the bit order in a configuration register. It picks and enables one of eight active-low chip selects in a control register. It then writes a byte to the transmit register. The block shifts that byte out on MOSI and captures a byte from MISO at the same time. When the transfer ends it raises a completion flag that software polls and then clears.

The serial clock comes from the core clock. The divisor is a 4-bit linear factor multiplied by two raised to a 3-bit exponent. The exponent is split across two configuration fields, and the block reassembles it before the divide. Each half period of SCLK lasts half the divisor in core cycles, and never less than one cycle.

Register word indices on `bus_addr`: 0 configuration, 1 control, 2 transmit data, 3 received data, 4 completion cause. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `spi_pm_top`

## Requirements
- R1: Configuration bits [3:0] hold the linear factor L, bit [4] holds exponent bit 0 and bits [11:10] hold exponent bits 2:1 (exponent E). The divisor is L·2^E, and each SCLK half period lasts max(1, floor(L·2^E/2)) core cycles. A transfer keeps the busy bit set for exactly 16 half periods.
- R2: While L is 0, a write to the transmit register is ignored: no SCLK edges, busy stays clear, and the completion cause stays clear.
- R3: Configuration bit [5] (polarity) sets the idle level of SCLK. With bit [6] (phase) clear, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With bit [6] set, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R4: Configuration bit [7] set sends the transmit byte LSB first, and bit [8] set places the first received bit in bit 0 of the received byte. When a bit is clear, its direction runs MSB first.
- R5: Writing the transmit register (index 2) while idle starts a transfer of its bits [7:0]. Control bit [8] reads back as busy. A transmit write while busy is ignored.
- R6: At the end of a transfer, bit 0 of the cause register (index 4) reads 1. Writing 0 to it clears it. The received byte reads from index 3.
- R7: Control bits [2:0] select chip select k, and control bit [3] enables it. While enabled, only cs_n[k] is low. While disabled, all cs_n lines are high.
- R8: Configuration bit [9] (byte-length) is stored and reads back. With it clear, every transfer is 8 bits long.
- R9: After reset all cs_n lines are high, SCLK is low, and the control, configuration and cause registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The bench times each transfer in core cycles at several divisor settings. These include the case where the divisor is 1 and the half period must be clamped to one cycle. They also include exponent values that touch only the low exponent field and only the high exponent field. A design that mis-joined the split exponent, or that did not clamp the half period, would report the wrong busy length.

A bus-functional slave runs in all four polarity/phase modes with mixed bit orders. A design that sampled on the wrong edge, or that reversed a byte, would return a corrupted byte on one side of the link.

Two further cases are checked at the port. A second transmit write during a transfer must not add a frame. A zero linear factor must leave SCLK silent. A design that restarted on that write would show extra edges, and one that ran with a zero factor would produce SCLK edges or a completion flag.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;
  localparam int LIN_W   = 4;
  localparam int EXP_W   = 3;
  localparam int CSN_W   = 3;
  localparam int NUM_CS  = 1 << CSN_W;
  localparam int FRAME_W = 8;
  localparam int BUSY_BIT = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG   = 3'd0,
    A_CTRL  = 3'd1,
    A_TXD   = 3'd2,
    A_RXD   = 3'd3,
    A_CAUSE = 3'd4
  } reg_addr_e;

  // bit 0..3 lin, 4 exp_lo, 5 cpol, 6 cpha, 7 tx_lsb, 8 rx_lsb, 9 blen, 10..11 exp_hi
  typedef struct packed {
    logic [EXP_W-2:0] exp_hi;
    logic             blen;
    logic             rx_lsb;
    logic             tx_lsb;
    logic             cpha;
    logic             cpol;
    logic             exp_lo;
    logic [LIN_W-1:0] lin;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/spi_pm_clkgen.sv
module spi_pm_clkgen #(
  parameter int LIN_W = 4,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LIN_W-1:0] lin,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int DIV_W = LIN_W + (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div, half, cnt_q, cnt_d;

  always_comb begin
    div  = DIV_W'(lin) << expo;
    half = ((div >> 1) == '0) ? DIV_W'(1) : (div >> 1);
    tick = run && (cnt_q == half - DIV_W'(1));
    cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_pm_engine.sv
module spi_pm_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tick,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         tx_lsb,
  input  logic         rx_lsb,
  input  logic [W-1:0] tx_data,
  input  logic         miso,
  output logic         busy,
  output logic         sclk,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx_data
);
  localparam int EDGES  = 2 * W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int IDX_W  = $clog2(W);

  logic              busy_q, busy_d, sclk_q, sclk_d, mosi_q, mosi_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [W-1:0]      tx_q, tx_d, rx_q, rx_d;
  logic              sample, last;

  function automatic logic pick(input logic [W-1:0] d, input logic lsb,
                                input logic [IDX_W-1:0] i);
    return lsb ? d[i] : d[(W-1) - int'(i)];
  endfunction

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    edge_d = edge_q;
    idx_d  = idx_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    sample = tick && (edge_q[0] == cpha);
    last   = tick && (edge_q == EDGE_W'(EDGES - 1));
    if (start) begin
      busy_d = 1'b1;
      sclk_d = cpol;
      edge_d = '0;
      tx_d   = tx_data;
      rx_d   = '0;
      if (!cpha) begin
        mosi_d = pick(tx_data, tx_lsb, '0);
        idx_d  = IDX_W'(1);
      end else begin
        idx_d  = '0;
      end
    end else if (tick) begin
      sclk_d = ~sclk_q;
      edge_d = edge_q + EDGE_W'(1);
      if (sample) begin
        rx_d = rx_lsb ? {miso, rx_q[W-1:1]} : {rx_q[W-2:0], miso};
      end else begin
        mosi_d = pick(tx_q, tx_lsb, idx_q);
        idx_d  = idx_q + IDX_W'(1);
      end
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      edge_q <= '0;
      idx_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      edge_q <= edge_d;
      idx_q  <= idx_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign sclk    = busy_q ? sclk_q : cpol;
  assign mosi    = mosi_q;
  assign done    = last;
  assign rx_data = rx_q;
endmodule

// File: rtl/spi_pm_regs.sv
module spi_pm_regs
  import spi_pm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  input  logic               busy,
  input  logic               done,
  input  logic [FRAME_W-1:0] rx_data,
  output cfg_t               cfg,
  output logic [CSN_W-1:0]   cs_num,
  output logic               cs_en,
  output logic               cause,
  output logic               start
);
  cfg_t             cfg_q, cfg_d;
  logic [CSN_W-1:0] num_q, num_d;
  logic             en_q, en_d, cause_q, cause_d;
  logic             wr_cfg, wr_ctrl, wr_txd, wr_cause;

  always_comb begin
    wr_cfg   = bus_wr && (bus_addr == A_CFG);
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_txd   = bus_wr && (bus_addr == A_TXD);
    wr_cause = bus_wr && (bus_addr == A_CAUSE);
    cfg_d    = wr_cfg  ? cfg_t'(bus_wdata[CFG_W-1:0]) : cfg_q;
    num_d    = wr_ctrl ? bus_wdata[CSN_W-1:0] : num_q;
    en_d     = wr_ctrl ? bus_wdata[CSN_W] : en_q;
    if (done)          cause_d = 1'b1;
    else if (wr_cause) cause_d = cause_q & bus_wdata[0];
    else               cause_d = cause_q;
    start = wr_txd && !busy && (cfg_q.lin != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      num_q   <= '0;
      en_q    <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      num_q   <= num_d;
      en_q    <= en_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:   bus_rdata[CFG_W-1:0] = cfg_q;
      A_CTRL: begin
        bus_rdata[CSN_W-1:0] = num_q;
        bus_rdata[CSN_W]     = en_q;
        bus_rdata[BUSY_BIT]  = busy;
      end
      A_RXD:   bus_rdata[FRAME_W-1:0] = rx_data;
      A_CAUSE: bus_rdata[0] = cause_q;
      default: bus_rdata = '0;
    endcase
  end

  assign cfg    = cfg_q;
  assign cs_num = num_q;
  assign cs_en  = en_q;
  assign cause  = cause_q;
endmodule

// File: rtl/spi_pm_top.sv
module spi_pm_top
  import spi_pm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_CS-1:0]  cs_n
);
  cfg_t               cfg;
  logic [CSN_W-1:0]   cs_num;
  logic               cs_en, cause, start, busy, done, tick;
  logic [FRAME_W-1:0] rx_data;

  spi_pm_regs i_regs (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .busy, .done, .rx_data, .cfg, .cs_num, .cs_en, .cause, .start
  );

  spi_pm_clkgen #(.LIN_W(LIN_W), .EXP_W(EXP_W)) i_clkgen (
    .clk, .rst_n, .run(busy), .lin(cfg.lin),
    .expo({cfg.exp_hi, cfg.exp_lo}), .tick
  );

  spi_pm_engine #(.W(FRAME_W)) i_engine (
    .clk, .rst_n, .start, .tick,
    .cpol(cfg.cpol), .cpha(cfg.cpha), .tx_lsb(cfg.tx_lsb), .rx_lsb(cfg.rx_lsb),
    .tx_data(bus_wdata[FRAME_W-1:0]), .miso,
    .busy, .sclk, .mosi, .done, .rx_data
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_en && (cs_num == CSN_W'(g)));
  end
endmodule

// File: rtl/spi_pm_chk.sv
module spi_pm_chk
  import spi_pm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input cfg_t              cfg,
  input logic              busy,
  input logic              done,
  input logic              sclk,
  input logic              cs_en,
  input logic              cause,
  input logic [NUM_CS-1:0] cs_n
);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg.cpol));

  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R7
  cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_en |-> ($countones(~cs_n) == 1));

  // R2
  zero_factor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TXD && !busy && cfg.lin == '0) |=> !busy);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R6
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cause);

  // R6
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause && !(bus_wr && bus_addr == A_CAUSE && !bus_wdata[0])) |=> cause);
endmodule

bind spi_pm_top spi_pm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cfg(cfg), .busy(busy), .done(done), .sclk(sclk),
  .cs_en(cs_en), .cause(cause), .cs_n(cs_n)
);

// File: tb/test_spi_pm_top.sv
module test_spi_pm_top;
  localparam int CLK_P = 10;

  logic        clk, rst_n, bus_wr, miso, sclk, mosi;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  cs_n;

  int checks = 0, fails = 0;

  spi_pm_top i_spi_pm_top (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .sclk, .mosi, .miso, .cs_n
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // slave model state
  logic       armed = 1'b0, s_cpha = 1'b0, s_txl = 1'b0, s_rxl = 1'b0;
  logic [7:0] s_out = 8'h00, s_in = 8'h00;
  int         ec = 0, s_bits = 0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always_comb begin
    int bi;
    bi = s_cpha ? ((ec == 0) ? 0 : (ec - 1) / 2) : ec / 2;
    if (bi > 7) bi = 7;
    miso = s_rxl ? s_out[bi] : s_out[7 - bi];
  end

  // monitor: slave samples MOSI and compares each completed frame
  always @(sclk) begin
    if (armed) begin
      if (((ec % 2) == 0) ^ s_cpha) begin
        s_in = s_txl ? {mosi, s_in[7:1]} : {s_in[6:0], mosi};
        s_bits++;
        if (s_bits % 8 == 0) begin
          if (exp_q.size() == 0) check(1'b0, "R5 unexpected extra frame", s_in, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(s_in == e, "R4/R3 MOSI byte at slave", s_in, e);
          end
        end
      end
      ec++;
    end
  end

  function automatic logic [31:0] cfgw(input int lin, input int ex, input bit cpol,
      input bit cpha, input bit txl, input bit rxl, input bit blen);
    return 32'(lin & 15) | (32'(ex & 1) << 4) | (32'(cpol) << 5) | (32'(cpha) << 6)
         | (32'(txl) << 7) | (32'(rxl) << 8) | (32'(blen) << 9) | (32'((ex >> 1) & 3) << 10);
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic do_xfer(input int lin, input int ex, input bit cpol, input bit cpha,
      input bit txl, input bit rxl, input logic [7:0] txb, input logic [7:0] rxb,
      input bit poke);
    int n, h;
    logic [31:0] d;
    wr_reg(3'd0, cfgw(lin, ex, cpol, cpha, txl, rxl, 1'b0));
    s_cpha = cpha; s_txl = txl; s_rxl = rxl; s_out = rxb;
    ec = 0; s_bits = 0; exp_q.push_back(txb); armed = 1'b1;
    check(sclk == cpol, "R3 SCLK idle level", sclk, cpol);
    wr_reg(3'd2, 32'(txb));
    n = 0;
    if (poke) begin wr_reg(3'd2, 32'(~txb)); n = 1; end
    bus_addr = 3'd1; #1;
    while (bus_rdata[8]) begin n++; @(negedge clk); #1; end
    h = ((lin << ex) >> 1); if (h == 0) h = 1;
    check(n == 16 * h, "R1 busy length in core cycles", n, 16 * h);
    repeat (3) @(negedge clk);
    armed = 1'b0;
    check(s_bits == 8, "R5/R8 SCLK sample edges per transfer", s_bits, 8);
    check(exp_q.size() == 0, "R4 frame reached slave", exp_q.size(), 0);
    rd_reg(3'd4, d); check(d == 1, "R6 cause set at end", d, 1);
    rd_reg(3'd3, d); check(d[7:0] == rxb, "R4 received byte", d[7:0], rxb);
    @(negedge clk);
    wr_reg(3'd4, 32'h0);
    rd_reg(3'd4, d); check(d == 0, "R6 cause cleared by writing 0", d, 0);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 8'hFF, "R9 cs_n after reset", cs_n, 8'hFF);
    check(sclk == 1'b0, "R9 sclk after reset", sclk, 0);
    rd_reg(3'd4, d); check(d == 0, "R9 cause after reset", d, 0);
    rd_reg(3'd1, d); check(d == 0, "R9 control after reset", d, 0);
    rd_reg(3'd0, d); check(d == 0, "R9 config after reset", d, 0);
    @(negedge clk);

    wr_reg(3'd1, 32'h8 | 32'd5);
    check(cs_n == 8'hDF, "R7 select line 5", cs_n, 8'hDF);
    wr_reg(3'd1, 32'h8);
    check(cs_n == 8'hFE, "R7 select line 0", cs_n, 8'hFE);
    wr_reg(3'd1, 32'd3);
    check(cs_n == 8'hFF, "R7 disabled keeps all high", cs_n, 8'hFF);
    wr_reg(3'd1, 32'h8 | 32'd2);

    wr_reg(3'd0, cfgw(2, 0, 0, 0, 0, 0, 1'b1));
    rd_reg(3'd0, d);
    check(d == cfgw(2, 0, 0, 0, 0, 0, 1'b1), "R8 byte-length bit read back", d,
          cfgw(2, 0, 0, 0, 0, 0, 1'b1));
    @(negedge clk);

    do_xfer(1, 0, 0, 0, 0, 0, 8'hA5, 8'h3C, 0);  // R1 clamp, mode 0
    do_xfer(5, 0, 0, 1, 0, 0, 8'hC3, 8'h81, 0);  // mode 1, odd divisor
    do_xfer(3, 1, 1, 0, 1, 1, 8'h96, 8'h5A, 0);  // mode 2, LSB first both
    do_xfer(3, 3, 1, 1, 1, 0, 8'h1E, 8'hE7, 0);  // mode 3, split exponent
    do_xfer(1, 2, 0, 0, 0, 1, 8'h70, 8'h0F, 1);  // R5 write while busy
    do_xfer(15, 7, 0, 1, 0, 0, 8'hB4, 8'h2D, 0); // largest divisor

    // R2 zero linear factor
    wr_reg(3'd0, cfgw(0, 2, 0, 0, 0, 0, 1'b0));
    ec = 0; armed = 1'b1;
    wr_reg(3'd2, 32'h55);
    repeat (20) @(negedge clk);
    check(ec == 0, "R2 no SCLK edges with zero factor", ec, 0);
    armed = 1'b0;
    rd_reg(3'd1, d); check(d[8] == 1'b0, "R2 busy stays clear", d[8], 0);
    rd_reg(3'd4, d); check(d == 0, "R2 cause stays clear", d, 0);
    @(negedge clk);

    wr_reg(3'd1, 32'h0);
    check(cs_n == 8'hFF, "R7 deassert after clearing enable", cs_n, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule